// File: doc/BRIEF.md
# Six-Layer Cathode Track Envelope Finder

The block looks for straight or slightly bent particle tracks in a chamber of six layers. Each layer arrives as a vector of half-strip hit bits. For every key column the block places a window over the layers. On the key layer the window is a single cell. On each of the other five layers it is three cells wide, centred on the key column. The block counts how many layers have a hit inside the window and picks the best key column. Only after the winner is chosen does it derive a bend-angle code from the cells of the winning window.

A new six-layer hit vector is accepted on every clock. The result (valid flag, key position, layer count, bend code) appears a fixed number of clocks later at registered outputs. Software-set inputs supply three controls: a per-column enable mask, a layer-count threshold, and a coarse mode in which each input bit stands for a pair of strips. The key layer is chosen at elaboration time (layer 3 or 4, default 4).

Top module: `pat_finder`

## Requirements
- R1: The layer count of a key column is the number of layers, out of six, with at least one hit inside that column's window. The window is the key cell on the key layer and cells k-1, k, k+1 on every other layer. The count is in the range 0 to 6.
- R2: Window cells that fall below index 0 or above index N_KEYS-1 count as no hit. There is no wrap-around.
- R3: The key layer is parameter KEY_LAYER (3 or 4, default 4). A hit on the key layer counts only in its own column and never in a neighbour's window.
- R4: `cell_en_i` bit p gates column p on all six layers. When it is 0, a hit at index p on any layer has no effect on any window.
- R5: A key column is a candidate only when its layer count is greater than or equal to `thresh_i`. With no candidate, `valid_o`, `key_o`, `nlayers_o` and `bend_o` are all 0.
- R6: Among candidates, the highest layer count wins.
- R7: On a layer-count tie, the candidate with more centre-cell hits (layers hit at exactly column k) wins. A remaining tie goes to the lowest key index.
- R8: The bend code is derived from the winner's window. A layer whose centre cell is hit is neutral. Otherwise a layer with its left cell (k-1) hit is a left layer, and otherwise a layer with its right cell (k+1) hit is a right layer. Let L and R be the numbers of left and right layers. The code is 0 when L equals R, {1'b0, R-L} when R exceeds L, and {1'b1, L-R} when L exceeds R. Bit 3 is the left-bend sign.
- R9: With `distrip_i` low, `key_o` equals the winning index. With `distrip_i` high, each input bit is a strip pair and `key_o` equals the index times 4, in half-strip units.
- R10: A new input is taken every clock. Its result appears LATENCY clocks later (default 3): the outputs after the third rising edge reflect the inputs present at the first.
- R11: Synchronous active-high `rst` clears all pipeline stages. Outputs read 0 after a reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hits_i | input | 6*N_KEYS | Hit bits, layer l at bits [l*N_KEYS +: N_KEYS] |
| cell_en_i | input | N_KEYS | Per-column enable mask |
| thresh_i | input | 3 | Minimum layer count for a candidate |
| distrip_i | input | 1 | Strip-pair mode |
| valid_o | output | 1 | A candidate was found |
| key_o | output | clog2(N_KEYS)+2 | Winning key position in half-strip units |
| nlayers_o | output | 3 | Layer count of the winner |
| bend_o | output | 4 | Bend code, bit 3 is the left sign |

## Verification
The bound checker checks the following on every cycle:
- the outputs are all zero when no candidate is valid;
- the layer count never exceeds six;
- the bend magnitude never exceeds the layer count, and a negative zero code never appears;
- a key with non-zero low bits always lies below N_KEYS;
- the outputs are clear after reset.

Which column wins, the edge handling, the mask, the key-layer asymmetry, the tie-break order, the exact bend value, the strip-pair scaling and the latency can only be shown by the bench's scenarios. These include hand-built tracks and a random stream compared cycle by cycle against an exhaustive scan model.

// File: rtl/pat_finder_pkg.sv
package pat_finder_pkg;

    localparam int NLAYERS = 6;

    // Per layer: [0] = column k-1, [1] = column k, [2] = column k+1
    typedef logic [NLAYERS-1:0][2:0] env_t;

    typedef struct packed {
        logic       valid;
        logic [2:0] nlay;
        logic [2:0] ncen;
        env_t       env;
    } cand_t;

    function automatic logic [2:0] env_layer_count(input env_t e);
        logic [2:0] c;
        c = 3'd0;
        for (int l = 0; l < NLAYERS; l++)
            if (|e[l]) c = c + 3'd1;
        return c;
    endfunction

    function automatic logic [2:0] env_centre_count(input env_t e);
        logic [2:0] c;
        c = 3'd0;
        for (int l = 0; l < NLAYERS; l++)
            if (e[l][1]) c = c + 3'd1;
        return c;
    endfunction

    function automatic logic [3:0] env_bend(input env_t e);
        logic [2:0] nl;
        logic [2:0] nr;
        nl = 3'd0;
        nr = 3'd0;
        for (int l = 0; l < NLAYERS; l++) begin
            if (!e[l][1]) begin
                if (e[l][0])      nl = nl + 3'd1;
                else if (e[l][2]) nr = nr + 3'd1;
            end
        end
        if (nl == nr)     return 4'd0;
        else if (nr > nl) return {1'b0, nr - nl};
        else              return {1'b1, nl - nr};
    endfunction

endpackage

// File: rtl/pf_envelope.sv
module pf_envelope
    import pat_finder_pkg::*;
#(
    parameter int N_KEYS    = 32,
    parameter int KEY_LAYER = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NLAYERS-1:0][N_KEYS-1:0] hits_i,
    input  logic [N_KEYS-1:0]             cell_en_i,
    output env_t                          envs_o [N_KEYS]
);

    logic [NLAYERS-1:0][N_KEYS-1:0] masked;
    env_t                           env_c [N_KEYS];

    for (genvar l = 0; l < NLAYERS; l++) begin : g_mask
        assign masked[l] = hits_i[l] & cell_en_i;
    end

    for (genvar k = 0; k < N_KEYS; k++) begin : g_key
        for (genvar l = 0; l < NLAYERS; l++) begin : g_lay
            assign env_c[k][l][1] = masked[l][k];
            if (l == KEY_LAYER) begin : g_keylay
                assign env_c[k][l][0] = 1'b0;
                assign env_c[k][l][2] = 1'b0;
            end else begin : g_wide
                if (k == 0) begin : g_lo_edge
                    assign env_c[k][l][0] = 1'b0;
                end else begin : g_lo
                    assign env_c[k][l][0] = masked[l][k-1];
                end
                if (k == N_KEYS-1) begin : g_hi_edge
                    assign env_c[k][l][2] = 1'b0;
                end else begin : g_hi
                    assign env_c[k][l][2] = masked[l][k+1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < N_KEYS; k++) begin
            if (rst) envs_o[k] <= '0;
            else     envs_o[k] <= env_c[k];
        end
    end

endmodule

// File: rtl/pf_select.sv
module pf_select
    import pat_finder_pkg::*;
#(
    parameter int N_KEYS = 32,
    localparam int KW    = $clog2(N_KEYS)
) (
    input  logic          clk,
    input  logic          rst,
    input  env_t          envs_i [N_KEYS],
    input  logic [2:0]    thresh_i,
    input  logic          distrip_i,
    output logic          valid_o,
    output logic [KW-1:0] idx_o,
    output logic [2:0]    nlay_o,
    output env_t          env_o,
    output logic          distrip_o
);

    cand_t         best;
    logic [KW-1:0] best_idx;

    always_comb begin
        best     = '0;
        best_idx = '0;
        for (int k = 0; k < N_KEYS; k++) begin
            cand_t c;
            c.env   = envs_i[k];
            c.nlay  = env_layer_count(envs_i[k]);
            c.ncen  = env_centre_count(envs_i[k]);
            c.valid = (c.nlay >= thresh_i);
            if (c.valid && (!best.valid || c.nlay > best.nlay ||
                            (c.nlay == best.nlay && c.ncen > best.ncen))) begin
                best     = c;
                best_idx = KW'(k);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o   <= 1'b0;
            idx_o     <= '0;
            nlay_o    <= '0;
            env_o     <= '0;
            distrip_o <= 1'b0;
        end else begin
            valid_o   <= best.valid;
            idx_o     <= best_idx;
            nlay_o    <= best.nlay;
            env_o     <= best.env;
            distrip_o <= distrip_i;
        end
    end

endmodule

// File: rtl/pf_bend.sv
module pf_bend
    import pat_finder_pkg::*;
#(
    parameter int N_KEYS  = 32,
    parameter int LATENCY = 3,
    localparam int KW     = $clog2(N_KEYS),
    localparam int KOW    = KW + 2,
    localparam int RW     = 1 + KOW + 3 + 4,
    localparam int EXTRA  = LATENCY - 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           valid_i,
    input  logic [KW-1:0]  idx_i,
    input  logic [2:0]     nlay_i,
    input  env_t           env_i,
    input  logic           distrip_i,
    output logic           valid_o,
    output logic [KOW-1:0] key_o,
    output logic [2:0]     nlayers_o,
    output logic [3:0]     bend_o
);

    logic [KOW-1:0] key_c;
    logic [RW-1:0]  res_q;
    logic [RW-1:0]  res_out;

    assign key_c = distrip_i ? {idx_i, 2'b00} : {2'b00, idx_i};

    always_ff @(posedge clk) begin
        if (rst || !valid_i) res_q <= '0;
        else                 res_q <= {1'b1, key_c, nlay_i, env_bend(env_i)};
    end

    if (EXTRA == 0) begin : g_direct
        assign res_out = res_q;
    end else begin : g_delay
        logic [RW-1:0] dly_q [EXTRA];
        always_ff @(posedge clk) begin
            for (int i = 0; i < EXTRA; i++) begin
                if (rst)         dly_q[i] <= '0;
                else if (i == 0) dly_q[i] <= res_q;
                else             dly_q[i] <= dly_q[i-1];
            end
        end
        assign res_out = dly_q[EXTRA-1];
    end

    assign {valid_o, key_o, nlayers_o, bend_o} = res_out;

endmodule

// File: rtl/pat_finder.sv
module pat_finder
    import pat_finder_pkg::*;
#(
    parameter int N_KEYS    = 32,
    parameter int KEY_LAYER = 4,
    parameter int LATENCY   = 3,
    localparam int KW       = $clog2(N_KEYS),
    localparam int KOW      = KW + 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [6*N_KEYS-1:0]     hits_i,
    input  logic [N_KEYS-1:0]       cell_en_i,
    input  logic [2:0]              thresh_i,
    input  logic                    distrip_i,
    output logic                    valid_o,
    output logic [KOW-1:0]          key_o,
    output logic [2:0]              nlayers_o,
    output logic [3:0]              bend_o
);

    env_t          envs_q [N_KEYS];
    logic [2:0]    thr_q;
    logic          ds_q;
    logic          sel_valid;
    logic [KW-1:0] sel_idx;
    logic [2:0]    sel_nlay;
    env_t          sel_env;
    logic          sel_ds;

    // Stage 1: window extraction, with the controls aligned to it
    pf_envelope #(.N_KEYS(N_KEYS), .KEY_LAYER(KEY_LAYER)) u_env (
        .clk       (clk),
        .rst       (rst),
        .hits_i    (hits_i),
        .cell_en_i (cell_en_i),
        .envs_o    (envs_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= '0;
            ds_q  <= 1'b0;
        end else begin
            thr_q <= thresh_i;
            ds_q  <= distrip_i;
        end
    end

    // Stage 2: winner selection
    pf_select #(.N_KEYS(N_KEYS)) u_sel (
        .clk       (clk),
        .rst       (rst),
        .envs_i    (envs_q),
        .thresh_i  (thr_q),
        .distrip_i (ds_q),
        .valid_o   (sel_valid),
        .idx_o     (sel_idx),
        .nlay_o    (sel_nlay),
        .env_o     (sel_env),
        .distrip_o (sel_ds)
    );

    // Stage 3: bend lookup on the winner, then optional extra delay
    pf_bend #(.N_KEYS(N_KEYS), .LATENCY(LATENCY)) u_bend (
        .clk       (clk),
        .rst       (rst),
        .valid_i   (sel_valid),
        .idx_i     (sel_idx),
        .nlay_i    (sel_nlay),
        .env_i     (sel_env),
        .distrip_i (sel_ds),
        .valid_o   (valid_o),
        .key_o     (key_o),
        .nlayers_o (nlayers_o),
        .bend_o    (bend_o)
    );

endmodule

// File: rtl/pat_finder_chk.sv
module pat_finder_chk #(
    parameter int N_KEYS = 32,
    localparam int KOW   = $clog2(N_KEYS) + 2
) (
    input logic           clk,
    input logic           rst,
    input logic           valid_o,
    input logic [KOW-1:0] key_o,
    input logic [2:0]     nlayers_o,
    input logic [3:0]     bend_o
);

    logic rst_d = 1'b0;
    always_ff @(posedge clk) rst_d <= rst;

    // R11: outputs cleared after a reset edge
    always @(negedge clk) begin
        if (rst_d) begin
            assert_reset_clear_R11: assert (!valid_o && nlayers_o == 3'd0 && bend_o == 4'd0);
        end
    end

    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> (key_o == '0 && nlayers_o == 3'd0 && bend_o == 4'd0));

    assert_count_range_R1: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> nlayers_o <= 3'd6);

    assert_bend_bound_R8: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (bend_o[2:0] <= nlayers_o && bend_o != 4'b1000));

    assert_key_range_R9: assert property (@(posedge clk) disable iff (rst)
        (key_o[1:0] != 2'b00) |-> (key_o < KOW'(N_KEYS)));

endmodule

bind pat_finder pat_finder_chk #(.N_KEYS(N_KEYS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_o   (valid_o),
    .key_o     (key_o),
    .nlayers_o (nlayers_o),
    .bend_o    (bend_o)
);

// File: tb/pat_finder_tb_top.sv
module pat_finder_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 32;
    localparam int KL         = 4;
    localparam int KOW        = $clog2(N) + 2;
    localparam int NSTREAM    = 200;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [6*N-1:0]  hits_i = '0;
    logic [N-1:0]    cell_en_i = '1;
    logic [2:0]      thresh_i = 3'd4;
    logic            distrip_i = 1'b0;
    logic            valid_o;
    logic [KOW-1:0]  key_o;
    logic [2:0]      nlayers_o;
    logic [3:0]      bend_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pat_finder dut_i (
        .clk       (clk),
        .rst       (rst),
        .hits_i    (hits_i),
        .cell_en_i (cell_en_i),
        .thresh_i  (thresh_i),
        .distrip_i (distrip_i),
        .valid_o   (valid_o),
        .key_o     (key_o),
        .nlayers_o (nlayers_o),
        .bend_o    (bend_o)
    );

    // Exhaustive scan model written from the requirements
    task automatic model(input logic [5:0][N-1:0] h, input logic [N-1:0] msk,
                         input int thr, input bit ds,
                         output logic ev, output int ek, output int en, output int eb);
        int bn, bc;
        ev = 1'b0; ek = 0; en = 0; eb = 0; bn = -1; bc = -1;
        for (int k = 0; k < N; k++) begin
            int cnt, cen, nl, nr;
            cnt = 0; cen = 0; nl = 0; nr = 0;
            for (int l = 0; l < 6; l++) begin
                bit c0, c1, c2;
                c1 = h[l][k] & msk[k];
                c0 = (l != KL && k > 0)   ? (h[l][k-1] & msk[k-1]) : 1'b0;
                c2 = (l != KL && k < N-1) ? (h[l][k+1] & msk[k+1]) : 1'b0;
                if (c0 | c1 | c2) cnt++;
                if (c1) cen++;
                else if (c0) nl++;
                else if (c2) nr++;
            end
            if (cnt >= thr && (cnt > bn || (cnt == bn && cen > bc))) begin
                bn = cnt; bc = cen; ev = 1'b1;
                ek = ds ? k * 4 : k;
                en = cnt;
                eb = (nl == nr) ? 0 : (nr > nl) ? (nr - nl) : (8 + nl - nr);
            end
        end
    endtask

    task automatic check(input string rq, input logic ev, input int ek, input int en, input int eb);
        n_checks++;
        if (valid_o !== ev || int'(key_o) != ek || int'(nlayers_o) != en || int'(bend_o) != eb) begin
            n_fail++;
            $display("FAIL %s: got v=%0b key=%0d n=%0d bend=%0d, expected v=%0b key=%0d n=%0d bend=%0d",
                     rq, valid_o, key_o, nlayers_o, bend_o, ev, ek, en, eb);
        end
    endtask

    // Drive at a falling edge, sample three rising edges later at a falling edge
    task automatic run_one(input logic [5:0][N-1:0] h, input logic [N-1:0] msk,
                           input int thr, input bit ds);
        hits_i = h; cell_en_i = msk; thresh_i = 3'(thr); distrip_i = ds;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_and_check(input string rq, input logic [5:0][N-1:0] h,
                                 input logic [N-1:0] msk, input int thr, input bit ds,
                                 input logic ev, input int ek, input int en, input int eb);
        logic mv; int mk, mn, mb;
        run_one(h, msk, thr, ds);
        check(rq, ev, ek, en, eb);
        model(h, msk, thr, ds, mv, mk, mn, mb);
        check({rq, " model"}, mv, mk, mn, mb);
    endtask

    function automatic logic [5:0][N-1:0] straight(input int k);
        logic [5:0][N-1:0] h;
        h = '0;
        for (int l = 0; l < 6; l++) h[l][k] = 1'b1;
        return h;
    endfunction

    task automatic t_reset();
        check("R11 reset state", 1'b0, 0, 0, 0);
    endtask

    task automatic t_straight();
        run_and_check("R1 straight six layers", straight(10), '1, 4, 0, 1'b1, 10, 6, 0);
    endtask

    task automatic t_edges();
        logic [5:0][N-1:0] h;
        h = '0;
        for (int l = 1; l < 6; l++) h[l][0] = 1'b1;
        h[0][N-1] = 1'b1;
        run_and_check("R2 low edge no wrap", h, '1, 4, 0, 1'b1, 0, 5, 0);
        run_and_check("R2 high edge", straight(N-1), '1, 4, 0, 1'b1, N-1, 6, 0);
    endtask

    task automatic t_key_layer();
        logic [5:0][N-1:0] h;
        h = '0;
        for (int l = 0; l < 6; l++) if (l != KL) h[l][5] = 1'b1;
        h[KL][6] = 1'b1;
        run_and_check("R3 R8 key layer single cell, left bend", h, '1, 4, 0, 1'b1, 6, 6, 13);
    endtask

    task automatic t_mask();
        logic [N-1:0] m;
        m = '1; m[10] = 1'b0;
        run_and_check("R4 masked column ignored", straight(10), m, 4, 0, 1'b0, 0, 0, 0);
    endtask

    task automatic t_threshold();
        logic [5:0][N-1:0] h;
        h = '0;
        for (int l = 0; l < 3; l++) h[l][12] = 1'b1;
        run_and_check("R5 below threshold", h, '1, 4, 0, 1'b0, 0, 0, 0);
        run_and_check("R5 at threshold", h, '1, 3, 0, 1'b1, 12, 3, 0);
    endtask

    task automatic t_count_wins();
        logic [5:0][N-1:0] h;
        h = '0;
        for (int l = 0; l < 4; l++) h[l][5] = 1'b1;
        h[0][20] = 1'b1; h[1][20] = 1'b1; h[2][20] = 1'b1; h[4][20] = 1'b1; h[5][20] = 1'b1;
        run_and_check("R6 higher count wins", h, '1, 4, 0, 1'b1, 20, 5, 0);
    endtask

    task automatic t_ties();
        logic [5:0][N-1:0] h;
        h = straight(25);
        h[0][7] = 1'b1; h[1][7] = 1'b1; h[2][8] = 1'b1; h[3][8] = 1'b1;
        h[4][8] = 1'b1; h[5][9] = 1'b1;
        run_and_check("R7 more centre hits wins", h, '1, 4, 0, 1'b1, 25, 6, 0);
        run_and_check("R7 lowest index wins", straight(7) | straight(20), '1, 4, 0, 1'b1, 7, 6, 0);
    endtask

    task automatic t_bend();
        logic [5:0][N-1:0] h;
        h = '0;
        for (int l = 0; l < 6; l++) if (l != KL) h[l][17] = 1'b1;
        h[KL][16] = 1'b1;
        run_and_check("R8 right bend", h, '1, 4, 0, 1'b1, 16, 6, 5);
        h = '0;
        h[0][17] = 1'b1; h[1][17] = 1'b1; h[2][16] = 1'b1; h[3][16] = 1'b1;
        h[5][16] = 1'b1; h[KL][16] = 1'b1;
        run_and_check("R8 mixed bend", h, '1, 4, 0, 1'b1, 16, 6, 2);
    endtask

    task automatic t_distrip();
        run_and_check("R9 strip-pair scaling", straight(9), '1, 4, 1, 1'b1, 36, 6, 0);
    endtask

    task automatic t_stream();
        logic ev [NSTREAM]; int ek [NSTREAM]; int en [NSTREAM]; int eb [NSTREAM];
        for (int i = 0; i < NSTREAM + 3; i++) begin
            if (i >= 3) begin
                n_checks++;
                if (valid_o !== ev[i-3] || int'(key_o) != ek[i-3] ||
                    int'(nlayers_o) != en[i-3] || int'(bend_o) != eb[i-3]) begin
                    n_fail++;
                    $display("FAIL R10 stream item %0d: got v=%0b key=%0d n=%0d bend=%0d, expected v=%0b key=%0d n=%0d bend=%0d",
                             i-3, valid_o, key_o, nlayers_o, bend_o, ev[i-3], ek[i-3], en[i-3], eb[i-3]);
                end
            end
            if (i < NSTREAM) begin
                logic [5:0][N-1:0] h; logic [N-1:0] m; int thr; bit ds;
                for (int l = 0; l < 6; l++) h[l] = $urandom & $urandom & $urandom;
                if (i % 4 == 0) h = h | straight($urandom_range(N-1));
                m   = (i % 5 == 0) ? ($urandom | $urandom) : '1;
                thr = $urandom_range(6, 1);
                ds  = (i % 7 == 0);
                model(h, m, thr, ds, ev[i], ek[i], en[i], eb[i]);
                hits_i = h; cell_en_i = m; thresh_i = 3'(thr); distrip_i = ds;
            end
            @(negedge clk);
        end
    endtask

    task automatic t_reset_mid();
        hits_i = straight(3); cell_en_i = '1; thresh_i = 3'd4; distrip_i = 1'b0;
        @(posedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R11 reset clears pipeline", 1'b0, 0, 0, 0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_straight();
        t_edges();
        t_key_layer();
        t_mask();
        t_threshold();
        t_count_wins();
        t_ties();
        t_bend();
        t_distrip();
        t_stream();
        t_reset_mid();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule